// File: doc/BRIEF.md
# Direct-Mapped Block Cache

This block is a direct-mapped cache placed between a processor's 32-bit load/store port and a backing memory whose data port is one full block wide. The processor presents a byte address. The cache splits that address into four fields. The two lowest bits select a byte and are ignored. The bits above them pick a word inside a block, the next bits pick a line, and all remaining upper bits are compared against the stored tag. Each line holds a valid bit, a tag and a block of several 32-bit words, and one comparator decides whether the access hits.

A load hit returns its word in the same cycle with no stall. On any miss the whole aligned block is fetched in one memory transaction, and the processor is stalled until the refilled line can satisfy the access. A parameter selects the store policy. With write-back, stores touch only the cache, a dirty flag marks the line, and a dirty victim is written out as a full block before the refill read. With write-through, every store also sends its single word to memory, and evictions never write. Two counters record how many accesses hit and how many missed, so that the miss rate can be measured.

Top module: `dm_cache`

## Requirements
- R1: Address bits [1:0] are ignored. Bits [2+W-1:2] select the word in the block (W = log2 words per block), the next log2(lines) bits select the line, and the rest form the tag.
- R2: An access hits only when the selected line is valid and its tag equals the address tag. A load hit drives the addressed word on `cpuRdata` with `cpuStall` low in the same cycle.
- R3: With 4 words per block, 4 lines and word addresses 1,2,3,4,10,11,1,2,3,17,18,2,3,4 loaded in order from reset, the outcomes are miss,hit,hit,miss,miss,hit,hit,hit,hit,miss,hit,miss,hit,hit.
- R4: A miss fills the entire aligned block, so every other word of that block then hits and returns the memory contents.
- R5: While a memory transaction is outstanding, `cpuStall` is high and `memReq` stays high until `memAck`. A miss stalls the processor for at least the memory latency.
- R6: In write-back mode a store hit completes without stall and leaves backing memory unchanged.
- R7: In write-back mode a dirty victim is written as a full block (all `memWmask` bits set) before the refill, and a clean victim causes no memory write.
- R8: In write-through mode each store writes exactly one word to memory (one `memWmask` bit set, the bit numbered by the word-select field), stalls until the write is acknowledged, and a replacement causes no memory write.
- R9: A store miss first fills the block and then writes the word, so a later load of that address hits and returns the stored value.
- R10: Reset clears all valid and dirty flags and both counters, so the first access after reset misses.
- R11: Every load returns the value most recently stored to that address, or the initial memory contents if none.
- R12: `hitCount` and `missCount` each increase by one per access according to its first lookup, and the refill-completing lookup is not counted again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cpuReq | input | 1 | Access request, held while `cpuStall` is high |
| cpuWe | input | 1 | 1 = store, 0 = load |
| cpuAddr | input | ADDR_W | Byte address |
| cpuWdata | input | 32 | Store data |
| cpuRdata | output | 32 | Load data, valid when `cpuStall` is low |
| cpuStall | output | 1 | Processor must hold the access |
| memReq | output | 1 | Memory transaction request, held until ack |
| memWe | output | 1 | 1 = write transaction |
| memAddr | output | ADDR_W-2-log2(WORDS) | Block address |
| memWdata | output | 32*WORDS | Write data, word 0 in the low bits |
| memWmask | output | WORDS | Per-word write enables |
| memRdata | input | 32*WORDS | Refill data, word 0 in the low bits |
| memAck | input | 1 | One-cycle completion pulse |
| hitCount | output | CNT_W | Number of accesses that hit |
| missCount | output | CNT_W | Number of accesses that missed |

## Verification
Two events can share one cycle. A refill's acknowledge can arrive in the same cycle as the replayed lookup that follows it, and in write-through mode a store hit updates the line while it opens the memory word write. The bench drives stores straight after misses to the same line, store misses that allocate, and dirty evictions that chain into a refill. It judges each access against a golden memory image, a model of tags, valid bits and stall length, and the write count seen by the memory model.

// File: rtl/dm_cache_pkg.sv
`timescale 1ns/1ps
package dm_cache_pkg;

  // Strobes from control to the line storage
  typedef struct packed {
    logic fill;       // load refill block, set valid, clear dirty
    logic writeWord;  // write the selected word with store data
    logic setDirty;   // mark line dirty together with writeWord
  } cacheStb_t;

  typedef enum logic [1:0] {
    ST_LOOK  = 2'd0,
    ST_EVICT = 2'd1,
    ST_FILL  = 2'd2,
    ST_WTHRU = 2'd3
  } cacheState_t;

endpackage

// File: rtl/dm_cache_dpath.sv
`timescale 1ns/1ps
module dm_cache_dpath
  import dm_cache_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int WORDS  = 4,
  parameter int LINES  = 8,
  localparam int WSEL_W = $clog2(WORDS),
  localparam int IDX_W  = $clog2(LINES),
  localparam int TAG_W  = ADDR_W - 2 - WSEL_W - IDX_W,
  localparam int BLK_W  = ADDR_W - 2 - WSEL_W,
  localparam int LINE_W = 32 * WORDS
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-3:0] wordAddr,
  input  logic [31:0]       cpuWdata,
  input  cacheStb_t         stb,
  input  logic [LINE_W-1:0] memRdata,
  output logic              hit,
  output logic              victimDirty,
  output logic [BLK_W-1:0]  victimBlk,
  output logic [LINE_W-1:0] lineData,
  output logic [31:0]       rdWord
);

  logic [WSEL_W-1:0] wordSel;
  logic [IDX_W-1:0]  idx;
  logic [TAG_W-1:0]  tagIn;

  assign wordSel = wordAddr[WSEL_W-1:0];
  assign idx     = wordAddr[WSEL_W +: IDX_W];
  assign tagIn   = wordAddr[ADDR_W-3 -: TAG_W];

  logic [LINES-1:0]  validArr;
  logic [LINES-1:0]  dirtyArr;
  logic [TAG_W-1:0]  tagArr  [LINES];
  logic [LINE_W-1:0] dataArr [LINES];

  // single tag comparator
  assign hit         = validArr[idx] && (tagArr[idx] == tagIn);
  assign victimDirty = validArr[idx] && dirtyArr[idx];
  assign victimBlk   = {tagArr[idx], idx};
  assign lineData    = dataArr[idx];
  assign rdWord      = lineData[wordSel*32 +: 32];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      validArr <= '0;
      dirtyArr <= '0;
    end else if (stb.fill) begin
      validArr[idx] <= 1'b1;
      dirtyArr[idx] <= 1'b0;
    end else if (stb.writeWord && stb.setDirty) begin
      dirtyArr[idx] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (stb.fill) begin
      tagArr[idx]  <= tagIn;
      dataArr[idx] <= memRdata;
    end else if (stb.writeWord) begin
      dataArr[idx][wordSel*32 +: 32] <= cpuWdata;
    end
  end

endmodule

// File: rtl/dm_cache_ctrl.sv
`timescale 1ns/1ps
module dm_cache_ctrl
  import dm_cache_pkg::*;
#(
  parameter int WRITE_BACK = 1,
  parameter int CNT_W      = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cpuReq,
  input  logic             cpuWe,
  input  logic             hit,
  input  logic             victimDirty,
  input  logic             memAck,
  output cacheStb_t        stb,
  output logic             memReq,
  output logic             memWe,
  output logic             memUseVictim,
  output logic             memWordOnly,
  output logic             cpuStall,
  output logic [CNT_W-1:0] hitCount,
  output logic [CNT_W-1:0] missCount
);

  localparam logic WB = (WRITE_BACK != 0);

  cacheState_t state, nxt;
  logic        replay;   // lookup after refill: not counted again

  always_comb begin
    nxt          = state;
    stb          = '0;
    memReq       = 1'b0;
    memWe        = 1'b0;
    memUseVictim = 1'b0;
    memWordOnly  = 1'b0;
    cpuStall     = 1'b0;
    unique case (state)
      ST_LOOK: if (cpuReq) begin
        if (hit) begin
          if (cpuWe) begin
            stb.writeWord = 1'b1;
            stb.setDirty  = WB;
            if (!WB) begin
              cpuStall = 1'b1;
              nxt      = ST_WTHRU;
            end
          end
        end else begin
          cpuStall = 1'b1;
          nxt      = victimDirty ? ST_EVICT : ST_FILL;
        end
      end
      ST_EVICT: begin
        memReq       = 1'b1;
        memWe        = 1'b1;
        memUseVictim = 1'b1;
        cpuStall     = 1'b1;
        if (memAck) nxt = ST_FILL;
      end
      ST_FILL: begin
        memReq   = 1'b1;
        cpuStall = 1'b1;
        if (memAck) begin
          stb.fill = 1'b1;
          nxt      = ST_LOOK;
        end
      end
      ST_WTHRU: begin
        memReq      = 1'b1;
        memWe       = 1'b1;
        memWordOnly = 1'b1;
        cpuStall    = !memAck;
        if (memAck) nxt = ST_LOOK;
      end
      default: nxt = ST_LOOK;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_LOOK;
      replay    <= 1'b0;
      hitCount  <= '0;
      missCount <= '0;
    end else begin
      state  <= nxt;
      replay <= stb.fill;
      if (state == ST_LOOK && cpuReq && !replay) begin
        if (hit) hitCount  <= hitCount + 1'b1;
        else     missCount <= missCount + 1'b1;
      end
    end
  end

endmodule

// File: rtl/dm_cache.sv
`timescale 1ns/1ps
module dm_cache
  import dm_cache_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int WORDS      = 4,
  parameter int LINES      = 8,
  parameter int WRITE_BACK = 1,
  parameter int CNT_W      = 16,
  localparam int WSEL_W = $clog2(WORDS),
  localparam int BLK_W  = ADDR_W - 2 - WSEL_W,
  localparam int LINE_W = 32 * WORDS
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cpuReq,
  input  logic              cpuWe,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic [31:0]       cpuWdata,
  output logic [31:0]       cpuRdata,
  output logic              cpuStall,
  output logic              memReq,
  output logic              memWe,
  output logic [BLK_W-1:0]  memAddr,
  output logic [LINE_W-1:0] memWdata,
  output logic [WORDS-1:0]  memWmask,
  input  logic [LINE_W-1:0] memRdata,
  input  logic              memAck,
  output logic [CNT_W-1:0]  hitCount,
  output logic [CNT_W-1:0]  missCount
);

  cacheStb_t          stb;
  logic               hit, victimDirty, memUseVictim, memWordOnly;
  logic [BLK_W-1:0]   victimBlk;
  logic [LINE_W-1:0]  lineData;
  logic [WSEL_W-1:0]  wordSel;
  logic [1:0]         unusedByteOfs;

  assign unusedByteOfs = cpuAddr[1:0];
  assign wordSel       = cpuAddr[2 +: WSEL_W];

  dm_cache_dpath #(.ADDR_W(ADDR_W), .WORDS(WORDS), .LINES(LINES)) u_dpath (
    .clk(clk), .rstN(rstN), .wordAddr(cpuAddr[ADDR_W-1:2]), .cpuWdata(cpuWdata),
    .stb(stb), .memRdata(memRdata), .hit(hit), .victimDirty(victimDirty),
    .victimBlk(victimBlk), .lineData(lineData), .rdWord(cpuRdata)
  );

  dm_cache_ctrl #(.WRITE_BACK(WRITE_BACK), .CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .cpuReq(cpuReq), .cpuWe(cpuWe), .hit(hit),
    .victimDirty(victimDirty), .memAck(memAck), .stb(stb), .memReq(memReq),
    .memWe(memWe), .memUseVictim(memUseVictim), .memWordOnly(memWordOnly),
    .cpuStall(cpuStall), .hitCount(hitCount), .missCount(missCount)
  );

  assign memAddr  = memUseVictim ? victimBlk : cpuAddr[ADDR_W-1 -: BLK_W];
  assign memWdata = memWordOnly ? {WORDS{cpuWdata}} : lineData;

  for (genvar w = 0; w < WORDS; w++) begin : g_mask
    assign memWmask[w] = memWe && (!memWordOnly || (wordSel == WSEL_W'(w)));
  end

endmodule

// File: rtl/dm_cache_chk.sv
`timescale 1ns/1ps
module dm_cache_chk #(
  parameter int WRITE_BACK = 1,
  parameter int WORDS      = 4,
  parameter int CNT_W      = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic             cpuStall,
  input logic             memReq,
  input logic             memWe,
  input logic [WORDS-1:0] memWmask,
  input logic             memAck,
  input logic [CNT_W-1:0] hitCount,
  input logic [CNT_W-1:0] missCount
);

  localparam logic [CNT_W:0] ONE = {{CNT_W{1'b0}}, 1'b1};
  logic [CNT_W:0] total;
  assign total = {1'b0, hitCount} + {1'b0, missCount};

  a_r5_stall_while_busy: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memAck) |-> cpuStall);

  a_r5_req_held: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memAck) |=> memReq);

  a_r7_full_block_write: assert property (@(posedge clk) disable iff (!rstN)
    (WRITE_BACK != 0 && memReq && memWe) |-> (&memWmask));

  a_r8_single_word_write: assert property (@(posedge clk) disable iff (!rstN)
    (WRITE_BACK == 0 && memReq && memWe) |-> ($countones(memWmask) == 1));

  a_r12_count_step: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((total - $past(total)) <= ONE));

  a_r10_counts_cleared: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (hitCount == '0 && missCount == '0));

endmodule

bind dm_cache dm_cache_chk #(.WRITE_BACK(WRITE_BACK), .WORDS(WORDS), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rstN(rstN), .cpuStall(cpuStall), .memReq(memReq), .memWe(memWe),
  .memWmask(memWmask), .memAck(memAck), .hitCount(hitCount), .missCount(missCount)
);

// File: tb/dm_cache_memmodel.sv
`timescale 1ns/1ps
module dm_cache_memmodel #(
  parameter int BLK_W = 4,
  parameter int WORDS = 4,
  parameter int LAT   = 6
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               memReq,
  input  logic               memWe,
  input  logic [BLK_W-1:0]   memAddr,
  input  logic [32*WORDS-1:0] memWdata,
  input  logic [WORDS-1:0]   memWmask,
  output logic [32*WORDS-1:0] memRdata,
  output logic               memAck
);

  localparam int DEPTH = (1 << BLK_W) * WORDS;
  logic [31:0] mem [DEPTH];
  int cnt;
  int writeCount;

  always @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= 32'hC0DE_0000 + i;
      memAck     <= 1'b0;
      memRdata   <= '0;
      cnt        <= 0;
      writeCount <= 0;
    end else begin
      memAck <= 1'b0;
      if (memReq && !memAck) begin
        if (cnt == LAT - 1) begin
          cnt    <= 0;
          memAck <= 1'b1;
          if (memWe) begin
            writeCount <= writeCount + 1;
            for (int w = 0; w < WORDS; w++)
              if (memWmask[w]) mem[memAddr*WORDS + w] <= memWdata[w*32 +: 32];
          end else begin
            for (int w = 0; w < WORDS; w++)
              memRdata[w*32 +: 32] <= mem[memAddr*WORDS + w];
          end
        end else begin
          cnt <= cnt + 1;
        end
      end
    end
  end

endmodule

// File: tb/dm_cache_bench.sv
`timescale 1ns/1ps
module dm_cache_bench;

  localparam int ADDR_W = 8;
  localparam int WORDS  = 4;
  localparam int LINES  = 4;
  localparam int BLK_W  = 4;
  localparam int LAT    = 6;
  localparam int NWORD  = 64;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #2 clk = ~clk;

  logic              cpuReq = 1'b0, cpuWe = 1'b0;
  logic [ADDR_W-1:0] cpuAddr = '0;
  logic [31:0]       cpuWdata = '0;
  int                tgt = 0;

  logic        reqB, reqT;
  logic [31:0] rdB, rdT;
  logic        stB, stT;
  logic        mReqB, mWeB, mAckB, mReqT, mWeT, mAckT;
  logic [BLK_W-1:0] mAddrB, mAddrT;
  logic [127:0] mWdB, mRdB, mWdT, mRdT;
  logic [3:0]   mMskB, mMskT;
  logic [15:0]  hitB, missB, hitT, missT;

  assign reqB = cpuReq && (tgt == 0);
  assign reqT = cpuReq && (tgt == 1);

  dm_cache #(.ADDR_W(ADDR_W), .WORDS(WORDS), .LINES(LINES), .WRITE_BACK(1)) u_dm_cache (
    .clk(clk), .rstN(rstN), .cpuReq(reqB), .cpuWe(cpuWe), .cpuAddr(cpuAddr),
    .cpuWdata(cpuWdata), .cpuRdata(rdB), .cpuStall(stB), .memReq(mReqB), .memWe(mWeB),
    .memAddr(mAddrB), .memWdata(mWdB), .memWmask(mMskB), .memRdata(mRdB), .memAck(mAckB),
    .hitCount(hitB), .missCount(missB));

  dm_cache #(.ADDR_W(ADDR_W), .WORDS(WORDS), .LINES(LINES), .WRITE_BACK(0)) u_dm_cache_wt (
    .clk(clk), .rstN(rstN), .cpuReq(reqT), .cpuWe(cpuWe), .cpuAddr(cpuAddr),
    .cpuWdata(cpuWdata), .cpuRdata(rdT), .cpuStall(stT), .memReq(mReqT), .memWe(mWeT),
    .memAddr(mAddrT), .memWdata(mWdT), .memWmask(mMskT), .memRdata(mRdT), .memAck(mAckT),
    .hitCount(hitT), .missCount(missT));

  dm_cache_memmodel #(.BLK_W(BLK_W), .WORDS(WORDS), .LAT(LAT)) u_memWb (
    .clk(clk), .rstN(rstN), .memReq(mReqB), .memWe(mWeB), .memAddr(mAddrB),
    .memWdata(mWdB), .memWmask(mMskB), .memRdata(mRdB), .memAck(mAckB));

  dm_cache_memmodel #(.BLK_W(BLK_W), .WORDS(WORDS), .LAT(LAT)) u_memWt (
    .clk(clk), .rstN(rstN), .memReq(mReqT), .memWe(mWeT), .memAddr(mAddrT),
    .memWdata(mWdT), .memWmask(mMskT), .memRdata(mRdT), .memAck(mAckT));

  int checks = 0;
  int fails  = 0;

  // independent reference: architectural memory and tag/valid model
  logic [31:0] gold [2][NWORD];
  bit          refV [2][LINES];
  int          refT [2][LINES];
  int          expHits [2];
  int          expMiss [2];

  function automatic logic [31:0] initWord(int a);
    return 32'hC0DE_0000 + a;
  endfunction

  function automatic bit predHit(int t, int wa);
    return refV[t][(wa / WORDS) % LINES] && refT[t][(wa / WORDS) % LINES] == wa / (WORDS * LINES);
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic access(input int t, input bit we, input int wa, input logic [31:0] wd,
                        input int byteOfs, output logic [31:0] rd, output int stallCyc,
                        output bit expHit);
    expHit = predHit(t, wa);
    if (expHit) expHits[t]++; else expMiss[t]++;
    tgt      = t;
    cpuReq   = 1'b1;
    cpuWe    = we;
    cpuAddr  = ADDR_W'(wa * 4 + byteOfs);
    cpuWdata = wd;
    stallCyc = 0;
    #1;
    while ((t == 0 ? stB : stT) && stallCyc < 1000) begin
      @(negedge clk); #1;
      stallCyc++;
    end
    rd = (t == 0) ? rdB : rdT;
    @(negedge clk);
    cpuReq = 1'b0;
    refV[t][(wa / WORDS) % LINES] = 1'b1;
    refT[t][(wa / WORDS) % LINES] = wa / (WORDS * LINES);
    if (we) gold[t][wa] = wd;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual %0d expected %0d", 150000, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin : main
    logic [31:0] rd;
    int st, wc;
    bit eh;
    int seqA [14] = '{1, 2, 3, 4, 10, 11, 1, 2, 3, 17, 18, 2, 3, 4};
    bit seqH [14] = '{0, 1, 1, 0, 0, 1, 1, 1, 1, 0, 1, 0, 1, 1};
    void'($urandom(32'd4242));
    for (int t = 0; t < 2; t++) begin
      for (int a = 0; a < NWORD; a++) gold[t][a] = initWord(a);
      for (int l = 0; l < LINES; l++) begin refV[t][l] = 0; refT[t][l] = 0; end
      expHits[t] = 0; expMiss[t] = 0;
    end
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R10 reset state
    chk(hitB == 0 && missB == 0, "R10", "wb counters after reset", {hitB, missB}, 0);
    chk(hitT == 0 && missT == 0, "R10", "wt counters after reset", {hitT, missT}, 0);
    chk(stB == 1'b0, "R10", "idle stall", 32'(stB), 0);

    // R3 directed sequence on the write-back instance
    for (int i = 0; i < 14; i++) begin
      access(0, 0, seqA[i], 0, 0, rd, st, eh);
      chk((st == 0) == seqH[i], "R3", $sformatf("outcome of access %0d", i), st, seqH[i] ? 0 : LAT);
      chk(rd == gold[0][seqA[i]], "R11", "sequence load data", rd, gold[0][seqA[i]]);
      if (!seqH[i]) chk(st >= LAT, "R5", "miss stall length", st, LAT);
    end

    // R4 other words of a refilled block
    for (int w = 5; w < 8; w++) begin
      access(0, 0, w, 0, 0, rd, st, eh);
      chk(st == 0 && rd == initWord(w), "R4", "block neighbour hit", rd, initWord(w));
    end

    // R1 byte offset ignored
    access(0, 0, 6, 0, 3, rd, st, eh);
    chk(st == 0 && rd == initWord(6), "R1", "byte offset 3", rd, initWord(6));

    // R6 write-back store hit
    wc = u_memWb.writeCount;
    access(0, 1, 5, 32'h5A5A_0005, 0, rd, st, eh);
    chk(st == 0, "R6", "store hit stall", st, 0);
    chk(u_memWb.mem[5] == initWord(5), "R6", "memory untouched", u_memWb.mem[5], initWord(5));
    access(0, 0, 5, 0, 0, rd, st, eh);
    chk(st == 0 && rd == 32'h5A5A_0005, "R2", "load after store hit", rd, 32'h5A5A_0005);

    // R7 dirty then clean victim
    access(0, 0, 21, 0, 0, rd, st, eh);
    chk(u_memWb.mem[5] == 32'h5A5A_0005, "R7", "dirty block written", u_memWb.mem[5], 32'h5A5A_0005);
    chk(u_memWb.writeCount == wc + 1, "R7", "one block write", u_memWb.writeCount, wc + 1);
    chk(st >= 2 * LAT, "R7", "evict plus refill stall", st, 2 * LAT);
    chk(rd == initWord(21), "R11", "load after evict", rd, initWord(21));
    access(0, 0, 37, 0, 0, rd, st, eh);
    chk(u_memWb.writeCount == wc + 1, "R7", "clean victim no write", u_memWb.writeCount, wc + 1);

    // R9 store miss allocates (write-back)
    access(0, 1, 40, 32'h7777_0040, 0, rd, st, eh);
    chk(st >= LAT, "R9", "store miss stalls", st, LAT);
    chk(u_memWb.mem[40] == initWord(40), "R6", "allocated store stays in cache", u_memWb.mem[40], initWord(40));
    access(0, 0, 40, 0, 0, rd, st, eh);
    chk(st == 0 && rd == 32'h7777_0040, "R9", "load after store miss", rd, 32'h7777_0040);

    // R8 write-through instance
    access(1, 0, 8, 0, 0, rd, st, eh);
    wc = u_memWt.writeCount;
    access(1, 1, 9, 32'h1234_0009, 0, rd, st, eh);
    chk(st > 0, "R8", "store waits for memory", st, 1);
    chk(u_memWt.mem[9] == 32'h1234_0009, "R8", "word reached memory", u_memWt.mem[9], 32'h1234_0009);
    chk(u_memWt.mem[8] == initWord(8), "R8", "neighbour word untouched", u_memWt.mem[8], initWord(8));
    chk(u_memWt.writeCount == wc + 1, "R8", "single write", u_memWt.writeCount, wc + 1);
    access(1, 0, 24, 0, 0, rd, st, eh);
    chk(u_memWt.writeCount == wc + 1, "R8", "no write on replacement", u_memWt.writeCount, wc + 1);
    access(1, 1, 50, 32'hBEEF_0050, 0, rd, st, eh);
    chk(u_memWt.mem[50] == 32'hBEEF_0050, "R8", "store miss word in memory", u_memWt.mem[50], 32'hBEEF_0050);
    access(1, 0, 50, 0, 0, rd, st, eh);
    chk(st == 0 && rd == 32'hBEEF_0050, "R9", "wt load after store miss", rd, 32'hBEEF_0050);
    access(1, 0, 9, 0, 0, rd, st, eh);
    chk(rd == 32'h1234_0009, "R11", "wt reload after replacement", rd, 32'h1234_0009);

    // random mix on both instances
    for (int n = 0; n < 600; n++) begin
      int t, wa, bo;
      bit we;
      logic [31:0] wd;
      t  = int'($urandom % 2);
      wa = int'($urandom % NWORD);
      bo = int'($urandom % 4);
      we = ($urandom % 3) == 0;
      wd = $urandom;
      access(t, we, wa, wd, bo, rd, st, eh);
      if (!we) begin
        chk(rd == gold[t][wa], "R11", "random load data", rd, gold[t][wa]);
        chk(eh ? (st == 0) : (st >= LAT), "R2", "random hit/miss stall", st, eh ? 0 : LAT);
      end else if (t == 0) begin
        chk(eh ? (st == 0) : (st >= LAT), "R6", "random wb store stall", st, eh ? 0 : LAT);
      end else begin
        chk(u_memWt.mem[wa] == wd, "R8", "random wt store in memory", u_memWt.mem[wa], wd);
      end
    end

    // R12 counters
    chk(32'(hitB) == expHits[0], "R12", "wb hit count", hitB, expHits[0]);
    chk(32'(missB) == expMiss[0], "R12", "wb miss count", missB, expMiss[0]);
    chk(32'(hitT) == expHits[1], "R12", "wt hit count", hitT, expHits[1]);
    chk(32'(missT) == expMiss[1], "R12", "wt miss count", missT, expMiss[1]);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule